// File: doc/BRIEF.md
# Display Self-Test Sequencer

This block runs the built-in self-test of a dot-matrix character display controller. A one-cycle start request, which is raised when the host writes the start-test bit of the control word, launches a fixed-length run. The run first walks the character-pattern ROM one row per clock and forms a checksum. It then drives two visual patterns onto the display through an override path. In the final cycle it pulses the strobes that put the display storage into its post-test state, and it records whether the checksum matched.

The run lasts `TOTAL` clocks in all. The ROM walk takes `GLYPHS*ROWS` clocks, and the remaining clocks are split equally between the checkerboard and its inverse. The `busy` output tells the surrounding bus logic to block host accesses. A start request that arrives while a run is in progress has no effect. The ROM port is a plain fixed-latency read: the address is valid while `rom_rd` is high, and the ROM must answer on `rom_dots` in the same cycle. This port has no back-pressure. The override output is combinational from `scan_row`, which the refresh logic supplies.

Top module: `selftest_seq`

## Requirements
- R1: When idle, a cycle with `start` high makes `busy` go high at the next clock edge. `busy` then stays high for exactly `TOTAL` cycles and falls at the following edge.
- R2: During the first `GLYPHS*ROWS` busy cycles, `rom_rd` is high. In busy cycle n (counting from 1), the address is glyph (n-1)/ROWS and row (n-1)%ROWS, with the glyph index major and the row index minor. At all other times `rom_rd` is low.
- R3: The checksum is the `SUM_W`-bit wrap-around sum of every `rom_dots` value read in the run. `pass` becomes 1 at the end of the run only if the checksum equals `EXPECT`, and 0 otherwise. Between completions, `pass` holds its value, including during the next run.
- R4: For the (TOTAL-GLYPHS*ROWS)/2 cycles after the ROM walk, `ovr_en` is 1. Bit (COLS-1-c) of `ovr_dots`, which is column c counted from the left, is 1 exactly when scan_row+c is even.
- R5: For the same number of cycles after that, `ovr_en` stays 1 and `ovr_dots` is the bitwise complement of the R4 pattern.
- R6: Outside the two pattern phases, `ovr_en` is 0 and `ovr_dots` is all zeros.
- R7: `clr_chars`, `clr_flash`, `set_udc_ptr` and `clr_ctrl` pulse together for exactly one cycle, in the last busy cycle, and are low at every other time.
- R8: A `start` request in any busy cycle, including one held high across several cycles, does not restart or lengthen the run.
- R9: While `rst_n` is low and after it is released, `busy`, `pass`, `rom_rd`, `ovr_en` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start-test request |
| rom_rd | output | 1 | ROM read enable |
| rom_glyph | output | $clog2(GLYPHS) | ROM glyph index |
| rom_row | output | $clog2(ROWS) | ROM row index |
| rom_dots | input | COLS | Row dots returned by the ROM in the same cycle |
| scan_row | input | $clog2(ROWS) | Row currently being refreshed |
| ovr_en | output | 1 | Pattern override active |
| ovr_dots | output | COLS | Override dots for scan_row, MSB leftmost |
| clr_chars | output | 1 | Load blank code into every character slot |
| clr_flash | output | 1 | Clear all flash attributes |
| set_udc_ptr | output | 1 | Set the user-glyph pointer to all ones |
| clr_ctrl | output | 1 | Zero the control word except the result bit |
| busy | output | 1 | Run in progress; host access forbidden |
| pass | output | 1 | Result of the most recent run |

## Verification
Each result appears at a fixed distance from the start request. `busy` and the first ROM address appear one edge after `start`. The address for busy cycle n and the override pattern are visible in that same cycle. `ovr_dots` follows `scan_row` with no clock delay. The strobes fall in busy cycle `TOTAL`, and `pass` and the drop of `busy` appear one edge later. The bench therefore drives inputs on the falling edge, counts busy cycles from the first falling edge after the request, and samples 1 ns later, so that every expected value is computed for the exact cycle index. Random `scan_row` values and injected start requests exercise R4, R5 and R8 in every cycle.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ROM  = 2'd1,
    PH_CHK  = 2'd2,
    PH_INV  = 2'd3
  } phase_e;
endpackage

// File: rtl/selftest_timer.sv
module selftest_timer
  import selftest_pkg::*;
#(
  parameter int ROM_LEN = 896,
  parameter int PAT_LEN = 130624,
  parameter int CW      = 18
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   accept,
  output logic   fin
);
  localparam logic [CW-1:0] ROM_LAST = CW'(ROM_LEN - 1);
  localparam logic [CW-1:0] PAT_LAST = CW'(PAT_LEN - 1);

  logic [CW-1:0] cnt;

  assign accept = start && (phase == PH_IDLE);
  assign fin    = (phase == PH_INV) && (cnt == PAT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_ROM;
          cnt   <= '0;
        end
        PH_ROM: if (cnt == ROM_LAST) begin
          phase <= PH_CHK;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_CHK: if (cnt == PAT_LAST) begin
          phase <= PH_INV;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_INV: if (cnt == PAT_LAST) begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R7
  fin_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (phase == PH_IDLE));
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !start) |=> (phase == PH_IDLE));
  // R8
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !fin) |=> (phase != PH_IDLE));
endmodule

// File: rtl/selftest_cksum.sv
module selftest_cksum #(
  parameter int GLYPHS = 128,
  parameter int ROWS   = 7,
  parameter int COLS   = 5,
  parameter int SUM_W  = 8,
  localparam int GW    = $clog2(GLYPHS),
  localparam int RW    = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rd,
  input  logic [COLS-1:0]  dots,
  output logic [GW-1:0]    glyph,
  output logic [RW-1:0]    row,
  output logic [SUM_W-1:0] sum
);
  localparam logic [RW-1:0] ROW_LAST   = RW'(ROWS - 1);
  localparam logic [GW-1:0] GLYPH_LAST = GW'(GLYPHS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glyph <= '0;
      row   <= '0;
      sum   <= '0;
    end else if (clr) begin
      glyph <= '0;
      row   <= '0;
      sum   <= '0;
    end else if (rd) begin
      sum <= sum + SUM_W'(dots);
      if (row == ROW_LAST) begin
        row   <= '0;
        glyph <= (glyph == GLYPH_LAST) ? '0 : glyph + 1'b1;
      end else begin
        row <= row + 1'b1;
      end
    end
  end

  // R2
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !clr && row == ROW_LAST) |=> (row == '0));
  // R3
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !clr) |=> $stable(sum));
endmodule

// File: rtl/selftest_pattern.sv
module selftest_pattern #(
  parameter int ROWS = 7,
  parameter int COLS = 5,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic            en,
  input  logic            inv,
  input  logic [RW-1:0]   scan_row,
  output logic [COLS-1:0] dots
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam logic CODD = (c % 2) == 1;
    assign dots[COLS-1-c] = en & ~(scan_row[0] ^ CODD ^ inv);
  end

  always_comb begin
    if (en) begin
      // R4
      adj_alt_chk: assert (dots[0] != dots[1]);
    end
  end
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
  import selftest_pkg::*;
#(
  parameter int          GLYPHS = 128,
  parameter int          ROWS   = 7,
  parameter int          COLS   = 5,
  parameter int          SUM_W  = 8,
  parameter int          TOTAL  = 262144,
  parameter logic [SUM_W-1:0] EXPECT = '0,
  localparam int GW = $clog2(GLYPHS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            rom_rd,
  output logic [GW-1:0]   rom_glyph,
  output logic [RW-1:0]   rom_row,
  input  logic [COLS-1:0] rom_dots,
  input  logic [RW-1:0]   scan_row,
  output logic            ovr_en,
  output logic [COLS-1:0] ovr_dots,
  output logic            clr_chars,
  output logic            clr_flash,
  output logic            set_udc_ptr,
  output logic            clr_ctrl,
  output logic            busy,
  output logic            pass
);
  localparam int ROM_LEN = GLYPHS * ROWS;
  localparam int PAT_LEN = (TOTAL - ROM_LEN) / 2;
  localparam int CW      = $clog2(TOTAL);

  phase_e           phase;
  logic             accept;
  logic             fin;
  logic [SUM_W-1:0] sum;

  selftest_timer #(.ROM_LEN(ROM_LEN), .PAT_LEN(PAT_LEN), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .phase(phase), .accept(accept), .fin(fin)
  );

  assign rom_rd = (phase == PH_ROM);
  assign busy   = (phase != PH_IDLE);
  assign ovr_en = (phase == PH_CHK) || (phase == PH_INV);

  selftest_cksum #(.GLYPHS(GLYPHS), .ROWS(ROWS), .COLS(COLS), .SUM_W(SUM_W)) u_cksum (
    .clk(clk), .rst_n(rst_n), .clr(accept), .rd(rom_rd), .dots(rom_dots),
    .glyph(rom_glyph), .row(rom_row), .sum(sum)
  );

  selftest_pattern #(.ROWS(ROWS), .COLS(COLS)) u_pat (
    .en(ovr_en), .inv(phase == PH_INV), .scan_row(scan_row), .dots(ovr_dots)
  );

  assign clr_chars   = fin;
  assign clr_flash   = fin;
  assign set_udc_ptr = fin;
  assign clr_ctrl    = fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pass <= 1'b0;
    else if (fin) pass <= (sum == EXPECT);
  end

  // R3
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(pass));
  // R1
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
  // R6
  ovr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_en |-> (ovr_dots == '0));
endmodule

// File: tb/selftest_seq_test.sv
module selftest_seq_test;
  localparam int GLYPHS  = 128;
  localparam int ROWS    = 7;
  localparam int COLS    = 5;
  localparam int TOTAL   = 2048;
  localparam int ROM_LEN = GLYPHS * ROWS;
  localparam int PAT_LEN = (TOTAL - ROM_LEN) / 2;

  function automatic logic [4:0] rom_fn(input int g, input int r);
    return 5'(((g * 13) + (r * 7) + (g >> 2)) ^ (r * 3));
  endfunction

  function automatic logic [7:0] calc_sum();
    logic [7:0] s = 8'd0;
    for (int g = 0; g < GLYPHS; g++)
      for (int r = 0; r < ROWS; r++)
        s = s + 8'(rom_fn(g, r));
    return s;
  endfunction

  localparam logic [7:0] GOOD = calc_sum();

  function automatic logic [4:0] pat_fn(input int row, input bit inv);
    logic [4:0] v;
    for (int c = 0; c < COLS; c++)
      v[COLS-1-c] = (((row + c) % 2) == 0) ^ inv;
    return v;
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic corrupt = 1'b0;
  logic [2:0] scan_row = 3'd0;
  logic rom_rd, ovr_en, clr_chars, clr_flash, set_udc_ptr, clr_ctrl, busy, pass;
  logic [6:0] rom_glyph;
  logic [2:0] rom_row;
  logic [4:0] rom_dots, ovr_dots;
  int n_chk = 0;
  int n_err = 0;
  bit prev_pass = 1'b0;

  always #4 clk = ~clk;

  assign rom_dots = rom_fn(int'(rom_glyph), int'(rom_row)) ^
                    ((corrupt && rom_glyph == 7'd77 && rom_row == 3'd3) ? 5'd1 : 5'd0);

  selftest_seq #(.GLYPHS(GLYPHS), .ROWS(ROWS), .COLS(COLS), .SUM_W(8),
                 .TOTAL(TOTAL), .EXPECT(GOOD)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rom_rd(rom_rd), .rom_glyph(rom_glyph), .rom_row(rom_row), .rom_dots(rom_dots),
    .scan_row(scan_row), .ovr_en(ovr_en), .ovr_dots(ovr_dots),
    .clr_chars(clr_chars), .clr_flash(clr_flash), .set_udc_ptr(set_udc_ptr),
    .clr_ctrl(clr_ctrl), .busy(busy), .pass(pass)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int strobes();
    return int'({clr_chars, clr_flash, set_udc_ptr, clr_ctrl});
  endfunction

  task automatic idle_checks(input string tag);
    chk(busy == 1'b0, {tag, " R1 busy low"}, int'(busy), 0);
    chk(rom_rd == 1'b0, {tag, " R2 rom_rd low"}, int'(rom_rd), 0);
    chk(ovr_en == 1'b0 && ovr_dots == 5'd0, {tag, " R6 override off"}, int'(ovr_dots), 0);
    chk(strobes() == 0, {tag, " R7 strobes low"}, strobes(), 0);
  endtask

  task automatic run_test(input bit bad, input int inj, input int hold);
    corrupt = bad;
    @(negedge clk);
    start = 1'b1;
    for (int i = 1; i <= TOTAL; i++) begin
      @(negedge clk);
      start = (i < hold) || (i == inj);
      scan_row = 3'($urandom % ROWS);
      #1;
      chk(busy == 1'b1, "R1 busy during run", int'(busy), 1);
      chk(pass == prev_pass, "R3 pass held during run", int'(pass), int'(prev_pass));
      chk(rom_rd == (i <= ROM_LEN), "R2 rom_rd window", int'(rom_rd), int'(i <= ROM_LEN));
      if (i <= ROM_LEN) begin
        chk(rom_glyph == 7'((i - 1) / ROWS), "R2 glyph index", int'(rom_glyph), (i - 1) / ROWS);
        chk(rom_row == 3'((i - 1) % ROWS), "R2 row index", int'(rom_row), (i - 1) % ROWS);
        chk(ovr_en == 1'b0 && ovr_dots == 5'd0, "R6 no override in ROM walk", int'(ovr_en), 0);
      end else if (i <= ROM_LEN + PAT_LEN) begin
        chk(ovr_en == 1'b1, "R4 override on", int'(ovr_en), 1);
        chk(ovr_dots == pat_fn(int'(scan_row), 1'b0), "R4 checkerboard",
            int'(ovr_dots), int'(pat_fn(int'(scan_row), 1'b0)));
      end else begin
        chk(ovr_en == 1'b1, "R5 override on", int'(ovr_en), 1);
        chk(ovr_dots == pat_fn(int'(scan_row), 1'b1), "R5 inverse checkerboard",
            int'(ovr_dots), int'(pat_fn(int'(scan_row), 1'b1)));
      end
      chk(strobes() == ((i == TOTAL) ? 15 : 0), "R7 strobe timing",
          strobes(), (i == TOTAL) ? 15 : 0);
    end
    @(negedge clk);
    start = 1'b0;
    #1;
    idle_checks("end R8");
    chk(pass == !bad, "R3 result", int'(pass), int'(!bad));
    prev_pass = !bad;
    repeat (3) begin
      @(negedge clk);
      #1;
      idle_checks("after");
      chk(pass == prev_pass, "R3 pass held idle", int'(pass), int'(prev_pass));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    #1;
    idle_checks("reset R9");
    chk(pass == 1'b0, "R9 pass in reset", int'(pass), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    idle_checks("post reset R9");
    chk(pass == 1'b0, "R9 pass after reset", int'(pass), 0);
    run_test(1'b0, 500 + int'($urandom % 400), 0);
    run_test(1'b1, TOTAL - 1, 0);
    run_test(1'b0, ROM_LEN + 1 + int'($urandom % (2 * PAT_LEN - 2)), 4);
    run_test(1'b0, 0, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule